// File: doc/BRIEF.md
# Event Counter and Input-Capture Timer

This block is a down-counting timer with two external inputs, A and B, and two operating modes. In event-counter mode the timer steps down by one on each chosen edge of input A. When it steps below zero it reloads from register A and raises a pending flag. Input B then works as a separate rising-edge interrupt source. In input-capture mode the timer runs freely at one step per system clock. A chosen edge on A copies the timer into register A, and a chosen edge on B copies it into register B. An underflow in this mode raises a flag of its own.

Both inputs pass through a two-flop synchronizer and an edge detector before they have any effect. Software reaches the block through a small register port with a write strobe, an address, write data and combinational read data. Through that port it sets the mode, the edge polarities and the interrupt enables, loads the timer and the two shared registers, and clears pending flags by writing ones. One interrupt line combines all enabled pending flags.

Top module: `evcap_timer`

## Requirements
- R1: After reset every readable location reads zero and `irq` is low.
- R2: A level on `pin_a` or `pin_b` that is stable before clock edge k takes effect on the block state at edge k+2. The input is registered at edge k and again at edge k+1, and the edge detector compares the second stage with its previous value.
- R3: Event-counter mode is selected when control bit 0 is 0. In this mode the timer decrements by one only on a selected edge of A. Control bit 1 selects the edge of A: 0 for rising, 1 for falling. Without such an edge the timer holds.
- R4: In event-counter mode, a selected A edge while the timer is 0 loads the timer from register A and sets flag bit 0 (pending A).
- R5: In event-counter mode, every rising edge of B sets flag bit 1 (pending B), whatever the value of control bit 2.
- R6: Input-capture mode is selected when control bit 0 is 1. In this mode the timer decrements on every clock. A step from 0 wraps to all ones and sets flag bit 2 (pending underflow).
- R7: In input-capture mode, a selected edge of A copies the timer value from before that clock edge into register A and sets flag bit 0. The same applies to B, register B and flag bit 1. Control bit 1 selects the edge of A and control bit 2 the edge of B, each with 0 for rising and 1 for falling.
- R8: Writing the flag location (address 4) clears each flag whose data bit is 1. A flag set in the same cycle as its clear stays set.
- R9: `irq` is high exactly when (pending A and enable A) or (pending B and enable B) or (pending underflow and enable A). Enable A is control bit 3 and enable B is control bit 4.
- R10: The register port uses these addresses:
  - 0: control, bits 4:0
  - 1: timer
  - 2: register A
  - 3: register B
  - 4: flags, bits 2:0

  A timer write overrides a count in the same cycle. A capture overrides a software write to its register in the same cycle.
- R11: Addresses 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | External input A (asynchronous) |
| pin_b | input | 1 | External input B (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a hardware event that lands in the same clock as a software write to the same state. Examples are an underflow colliding with a flag clear, a capture colliding with a write to its register, or a count colliding with a timer load. The input synchronizer delays every pin change by two clocks, which makes these collisions hard to set up by hand. The stimulus therefore mixes long runs of random pin toggles with frequent writes of small timer values, so the timer reaches zero often. Directed sequences add a timer load of zero followed at once by a flag clear in capture mode, and a B edge in counter mode with the B polarity set to falling.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_TMR  = 3'd1,
        ADR_REGA = 3'd2,
        ADR_REGB = 3'd3,
        ADR_FLAG = 3'd4
    } addr_e;

    typedef struct packed {
        logic en_b;
        logic en_a;
        logic pol_b;
        logic pol_a;
        logic cap_mode;
    } ctrl_t;

    localparam int unsigned CTRL_W = 5;
    localparam int unsigned NFLAG  = 3;
    localparam int unsigned FLG_A  = 0;
    localparam int unsigned FLG_B  = 1;
    localparam int unsigned FLG_U  = 2;

endpackage

// File: rtl/evcap_edge.sv
module evcap_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d;
    logic [DEPTH-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/evcap_core.sv
module evcap_core
    import evcap_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             a_rise,
    input  logic             a_fall,
    input  logic             b_rise,
    input  logic             b_fall,
    input  logic             tmr_we,
    input  logic             ra_we,
    input  logic             rb_we,
    input  logic [TW-1:0]    wdata,
    input  logic [NFLAG-1:0] flag_clr,
    output logic [TW-1:0]    tmr,
    output logic [TW-1:0]    reg_a,
    output logic [TW-1:0]    reg_b,
    output logic [NFLAG-1:0] pend,
    output logic             ev_a,
    output logic             ev_b
);
    typedef struct packed {
        logic [TW-1:0]    tmr;
        logic [TW-1:0]    ra;
        logic [TW-1:0]    rb;
        logic [NFLAG-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    logic             tick;
    logic             uf;
    logic [NFLAG-1:0] set;

    always_comb begin
        ev_a = ctrl.pol_a ? a_fall : a_rise;
        ev_b = (ctrl.cap_mode && ctrl.pol_b) ? b_fall : b_rise;
        tick = ctrl.cap_mode | ev_a;
        uf   = tick && (st_q.tmr == '0);

        st_d = st_q;

        if (tmr_we) begin
            st_d.tmr = wdata;
        end else if (tick) begin
            if (uf) st_d.tmr = ctrl.cap_mode ? {TW{1'b1}} : st_q.ra;
            else    st_d.tmr = st_q.tmr - 1'b1;
        end

        if (ctrl.cap_mode && ev_a) st_d.ra = st_q.tmr;
        else if (ra_we)            st_d.ra = wdata;

        if (ctrl.cap_mode && ev_b) st_d.rb = st_q.tmr;
        else if (rb_we)            st_d.rb = wdata;

        set        = '0;
        set[FLG_A] = ctrl.cap_mode ? ev_a : uf;
        set[FLG_B] = ev_b;
        set[FLG_U] = ctrl.cap_mode & uf;

        st_d.pend = (st_q.pend & ~flag_clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr   = st_q.tmr;
    assign reg_a = st_q.ra;
    assign reg_b = st_q.rb;
    assign pend  = st_q.pend;

endmodule

// File: rtl/evcap_timer.sv
module evcap_timer
    import evcap_pkg::*;
#(
    parameter int unsigned TW     = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_a,
    input  logic          pin_b,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] rdata,
    output logic          irq
);
    localparam int unsigned NIN = 2;

    ctrl_t ctrl_d, ctrl_q;

    logic [NIN-1:0]   pins;
    logic [NIN-1:0]   rises;
    logic [NIN-1:0]   falls;
    logic [TW-1:0]    tmr;
    logic [TW-1:0]    reg_a;
    logic [TW-1:0]    reg_b;
    logic [NFLAG-1:0] pend;
    logic [NFLAG-1:0] flag_clr;
    logic             ev_a;
    logic             ev_b;
    logic             tmr_we;
    logic             ra_we;
    logic             rb_we;
    logic             ctrl_we;

    assign pins = {pin_b, pin_a};

    for (genvar gi = 0; gi < NIN; gi++) begin : g_in
        evcap_edge #(.STAGES(STAGES)) i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[gi]),
            .rise (rises[gi]),
            .fall (falls[gi])
        );
    end

    always_comb begin
        ctrl_we  = wr_en && (addr == ADR_CTRL);
        tmr_we   = wr_en && (addr == ADR_TMR);
        ra_we    = wr_en && (addr == ADR_REGA);
        rb_we    = wr_en && (addr == ADR_REGB);
        flag_clr = (wr_en && (addr == ADR_FLAG)) ? wdata[NFLAG-1:0] : '0;
        ctrl_d   = ctrl_we ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    evcap_core #(.TW(TW)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl_q),
        .a_rise  (rises[0]),
        .a_fall  (falls[0]),
        .b_rise  (rises[1]),
        .b_fall  (falls[1]),
        .tmr_we  (tmr_we),
        .ra_we   (ra_we),
        .rb_we   (rb_we),
        .wdata   (wdata),
        .flag_clr(flag_clr),
        .tmr     (tmr),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .pend    (pend),
        .ev_a    (ev_a),
        .ev_b    (ev_b)
    );

    always_comb begin
        case (addr)
            ADR_CTRL: rdata = TW'(ctrl_q);
            ADR_TMR:  rdata = tmr;
            ADR_REGA: rdata = reg_a;
            ADR_REGB: rdata = reg_b;
            ADR_FLAG: rdata = TW'(pend);
            default:  rdata = '0;
        endcase
        irq = (pend[FLG_A] & ctrl_q.en_a) |
              (pend[FLG_B] & ctrl_q.en_b) |
              (pend[FLG_U] & ctrl_q.en_a);
    end

endmodule

// File: rtl/evcap_timer_chk.sv
module evcap_timer_chk #(
    parameter int unsigned TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_mode,
    input logic          ev_a,
    input logic          ev_b,
    input logic          tmr_we,
    input logic [TW-1:0] tmr,
    input logic [TW-1:0] reg_a,
    input logic [TW-1:0] reg_b,
    input logic [2:0]    pend,
    input logic          irq
);
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && !ev_a && !tmr_we) |=> $stable(tmr)); // R3

    AST_CTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && ev_a && !tmr_we && tmr == '0) |=> (tmr == $past(reg_a) && pend[0])); // R4

    AST_CAP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !tmr_we && tmr != '0) |=> (tmr == $past(tmr) - 1'b1)); // R6

    AST_CAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !tmr_we && tmr == '0) |=> (tmr == {TW{1'b1}} && pend[2])); // R6

    AST_CAPT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && ev_a) |=> (reg_a == $past(tmr) && pend[0])); // R7

    AST_CAPT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && ev_b) |=> (reg_b == $past(tmr) && pend[1])); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 3'b000) |-> !irq); // R9

endmodule

bind evcap_timer evcap_timer_chk #(.TW(TW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_mode(ctrl_q.cap_mode),
    .ev_a    (ev_a),
    .ev_b    (ev_b),
    .tmr_we  (tmr_we),
    .tmr     (tmr),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .pend    (pend),
    .irq     (irq)
);

// File: tb/test_evcap_timer.sv
module test_evcap_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evcap_timer i_evcap_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_a(pin_a),
        .pin_b(pin_b),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    // reference state built from the requirements
    logic [4:0]  m_ctrl;
    logic [15:0] m_tmr, m_ra, m_rb;
    logic [2:0]  m_pend;
    logic [2:0]  m_sa, m_sb;

    function automatic logic [15:0] m_read(input logic [2:0] ad);
        case (ad)
            3'd0: return {11'd0, m_ctrl};
            3'd1: return m_tmr;
            3'd2: return m_ra;
            3'd3: return m_rb;
            3'd4: return {13'd0, m_pend};
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_pend[0] & m_ctrl[3]) | (m_pend[1] & m_ctrl[4]) | (m_pend[2] & m_ctrl[3]);
    endfunction

    task automatic m_reset();
        m_ctrl = '0; m_tmr = '0; m_ra = '0; m_rb = '0; m_pend = '0;
        m_sa = '0; m_sb = '0;
    endtask

    task automatic m_advance(input logic we, input logic [2:0] ad, input logic [15:0] wd,
                             input logic pa, input logic pb);
        logic cap, ea, eb, tick, uf;
        logic [15:0] nt, nra, nrb;
        logic [2:0] set, clr;
        cap  = m_ctrl[0];
        ea   = m_ctrl[1] ? (~m_sa[1] & m_sa[2]) : (m_sa[1] & ~m_sa[2]);
        eb   = (cap && m_ctrl[2]) ? (~m_sb[1] & m_sb[2]) : (m_sb[1] & ~m_sb[2]);
        tick = cap | ea;
        uf   = tick && (m_tmr == 16'd0);
        nt   = m_tmr;
        if (we && ad == 3'd1) nt = wd;
        else if (tick) nt = uf ? (cap ? 16'hFFFF : m_ra) : m_tmr - 16'd1;
        nra = m_ra;
        if (cap && ea) nra = m_tmr; else if (we && ad == 3'd2) nra = wd;
        nrb = m_rb;
        if (cap && eb) nrb = m_tmr; else if (we && ad == 3'd3) nrb = wd;
        set = {cap & uf, eb, cap ? ea : uf};
        clr = (we && ad == 3'd4) ? wd[2:0] : 3'd0;
        m_pend = (m_pend & ~clr) | set;
        m_tmr = nt; m_ra = nra; m_rb = nrb;
        if (we && ad == 3'd0) m_ctrl = wd[4:0];
        m_sa = {m_sa[1:0], pa};
        m_sb = {m_sb[1:0], pb};
    endtask

    function automatic string tag_of(input logic [2:0] ad);
        case (ad)
            3'd0: return "R10";
            3'd1: return m_ctrl[0] ? "R6" : "R3";
            3'd2: return m_ctrl[0] ? "R7" : "R4";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare outputs, then advance the model at posedge
    task automatic step(input logic we, input logic [2:0] ad, input logic [15:0] wd,
                        input logic pa, input logic pb, input string req);
        string t;
        wr_en = we; addr = ad; wdata = wd; pin_a = pa; pin_b = pb;
        #1;
        t = (req == "") ? tag_of(ad) : req;
        check(t, rdata, m_read(ad));
        check("R9", {15'd0, irq}, {15'd0, m_irq()});
        m_advance(we, ad, wd, pa, pb);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic sa, sb;
        void'($urandom(32'h5EED1234));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every location
        for (int i = 0; i < 8; i++) step(1'b0, 3'(i), 16'd0, 1'b0, 1'b0, "R1");

        // R2 / R3: counter mode, rising A, timer 5; latency through synchronizer
        step(1'b1, 3'd0, 16'h0018, 1'b0, 1'b0, "R10");
        step(1'b1, 3'd1, 16'd5, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 5; i++) step(1'b0, 3'd1, 16'd0, 1'b1, 1'b0, "R2");
        // R4: count down to zero and reload from register A
        step(1'b1, 3'd2, 16'h0033, 1'b1, 1'b0, "R10");
        step(1'b1, 3'd1, 16'd0, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 5; i++) step(1'b0, 3'd1, 16'd0, 1'b1, 1'b0, "R4");
        step(1'b0, 3'd4, 16'd0, 1'b1, 1'b0, "R4");
        // R5: B rising edge in counter mode with B polarity set to falling
        step(1'b1, 3'd0, 16'h001C, 1'b0, 1'b0, "R10");
        step(1'b1, 3'd4, 16'h0007, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 5; i++) step(1'b0, 3'd4, 16'd0, 1'b0, 1'b1, "R5");
        // R11: out of range write ignored
        step(1'b1, 3'd6, 16'hFFFF, 1'b0, 1'b1, "R11");
        for (int i = 0; i < 5; i++) step(1'b0, 3'(i), 16'd0, 1'b0, 1'b1, "R11");
        // R6 / R8: capture mode, underflow colliding with flag clear
        step(1'b1, 3'd0, 16'h0019, 1'b0, 1'b1, "R10");
        step(1'b1, 3'd1, 16'd0, 1'b0, 1'b1, "R6");
        step(1'b1, 3'd4, 16'h0007, 1'b0, 1'b1, "R8");
        step(1'b0, 3'd4, 16'd0, 1'b0, 1'b1, "R8");
        step(1'b0, 3'd1, 16'd0, 1'b0, 1'b1, "R6");

        // constrained random mix
        sa = 1'b0; sb = 1'b0;
        for (int n = 0; n < 20000; n++) begin
            logic we;
            logic [2:0] ad;
            logic [15:0] wd;
            if ($urandom_range(99) < 20) sa = ~sa;
            if ($urandom_range(99) < 15) sb = ~sb;
            we = ($urandom_range(99) < 12);
            ad = 3'($urandom_range(7));
            wd = 16'($urandom);
            if (ad == 3'd1 || ad == 3'd2) wd = wd & 16'h000F;
            if (ad == 3'd0 && $urandom_range(3) != 0) wd[0] = m_ctrl[0];
            step(we, ad, wd, sa, sb, "");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule